// File: doc/BRIEF.md
# Hardware Cursor Line Overlay

This block sits in a display pipeline and paints a two-plane hardware cursor over one scanline of 24-bit pixels. When a cursor line begins, it reads two 32-bit mask words from video memory: the AND plane at the current line address, then the XOR plane 128 bytes further on. It then watches the incoming pixel stream. Inside the cursor window it blanks pixels where the AND bit is clear and inverts pixels where the XOR bit is set. Every pixel leaves one clock after it arrives.

The line address is loaded from a cursor base at the start of each frame. It advances by one 4-byte word for each cursor line, and skips one more word per line during odd interlaced fields. The position and mode are captured at each line start. A half-width mode is chosen automatically for high-resolution 8 bpp timings. In that mode the cursor covers 16 pixels, uses two mask bits per pixel, and its start column is halved.

Top module: `cursor_overlay`

## Requirements
- R1: After reset no memory read is requested, and until the first mask fetch completes every pixel is passed through unchanged.
- R2: `pixOutValid` follows `pixInValid` one cycle later. A pixel outside the cursor window leaves unchanged one cycle after it enters.
- R3: On `lineStart` the block reads the AND word at the fetch address, then the XOR word at the fetch address plus 128. It holds `memAddr` while waiting for `memRdValid`. Each word is big-endian: bits 31:24 are the byte at the lowest address, and bit 31 covers the first cursor pixel.
- R4: Inside the window, a pixel whose AND bit is 0 becomes 0x000000.
- R5: Inside the window, a pixel whose XOR bit is 1 is XORed with 0xFFFFFF after the AND step, so AND=0 and XOR=1 gives 0xFFFFFF.
- R6: In normal mode the window covers 32 valid pixels starting at column `xPos + xOff`. Columns count the valid pixels since `lineStart`. Pixel k of the window uses mask bit 31-k.
- R7: In half-width mode the window covers 16 pixels starting at column `(xPos + xOff) >> 1`. Pixel k of the window uses mask bit 31-2k.
- R8: Half-width mode is chosen at `lineStart` when `is8bpp` is set and `hTotal*8` is strictly greater than `vTotal*4` (interlaced) or `vTotal*2` (progressive).
- R9: When `interlaced` and `oddField` are both set at `lineStart`, the line address is first increased by 4. The fetch uses the increased value.
- R10: `frameStart` loads the line address with `((curSel<<6) | (3<<14) | (curBank<<16)) << 2`. After each line's fetch address is used, the line address becomes that fetch address plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Reload line address from the cursor base |
| lineStart | input | 1 | Begin a cursor line: latch mode and position, fetch masks |
| curSel | input | 8 | Cursor base select, placed at address bits 13:6 before the final shift |
| curBank | input | 2 | Cursor bank, placed at bits 17:16 before the final shift |
| xPos | input | X_W | Cursor horizontal position |
| xOff | input | X_W | Horizontal offset added to the position |
| is8bpp | input | 1 | Display is 8 bits per pixel |
| interlaced | input | 1 | Interlaced scanout |
| oddField | input | 1 | Current field is odd |
| hTotal | input | T_W | Horizontal total |
| vTotal | input | T_W | Vertical total |
| memRdReq | output | 1 | Mask read request |
| memAddr | output | ADDR_W | Byte address of the mask word |
| memRdValid | input | 1 | Read data valid for the current request |
| memRdData | input | 32 | Mask word, big-endian |
| pixInValid | input | 1 | Input pixel valid |
| pixIn | input | 24 | Input pixel |
| pixOutValid | output | 1 | Output pixel valid |
| pixOut | output | 24 | Output pixel |

## Verification
The hardest case to reach from the ports is the cumulative address walk over interlaced odd fields. The odd-field skip and the per-line step only show up as memory addresses, several lines after the frame base was loaded. The bench models the memory and queues each requested address. It then runs several cursor lines in a row after one `frameStart`, toggling `oddField`, and compares every fetch address against a running model. The half-width decision is driven to the exact equality boundary of the timing rule in both progressive and interlaced scans, and is then observed through the width of the modified pixel run.

// File: rtl/cursor_overlay_pkg.sv
package cursor_overlay_pkg;
  localparam int MASK_W    = 32;
  localparam int XOR_GAP   = 128;
  localparam int LINE_STEP = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_GET_AND, ST_GET_XOR} fetchState_e;

  typedef struct packed {
    logic loadAnd;
    logic loadXor;
    logic apply;
    logic twoBit;
  } ovlStrobe_t;
endpackage

// File: rtl/cursor_overlay_ctrl.sv
module cursor_overlay_ctrl
  import cursor_overlay_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int X_W    = 11,
  parameter int T_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              lineStart,
  input  logic [7:0]        curSel,
  input  logic [1:0]        curBank,
  input  logic [X_W-1:0]    xPos,
  input  logic [X_W-1:0]    xOff,
  input  logic              is8bpp,
  input  logic              interlaced,
  input  logic              oddField,
  input  logic [T_W-1:0]    hTotal,
  input  logic [T_W-1:0]    vTotal,
  input  logic              pixInValid,
  input  logic              memRdValid,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memAddr,
  output ovlStrobe_t        strobe
);
  localparam int COL_W = X_W + 1;
  localparam int MUL_W = T_W + 3;

  fetchState_e       state;
  logic [ADDR_W-1:0] lineAddr, fetchAddr, baseAddr, srcAddr, nextFetch;
  logic              armed, halfLat;
  logic [COL_W-1:0]  startLat, col, posSum, startNext;
  logic [COL_W:0]    diff;
  logic [MUL_W-1:0]  hMul, vMul;
  logic              halfNext, inWin;

  assign baseAddr  = ADDR_W'({curBank, 2'b11, curSel, 8'h00});
  assign srcAddr   = frameStart ? baseAddr : lineAddr;
  assign nextFetch = srcAddr + ((interlaced && oddField) ? ADDR_W'(LINE_STEP) : '0);

  assign hMul      = {hTotal, 3'b000};
  assign vMul      = interlaced ? {1'b0, vTotal, 2'b00} : {2'b00, vTotal, 1'b0};
  assign halfNext  = is8bpp && (hMul > vMul);
  assign posSum    = COL_W'(xPos) + COL_W'(xOff);
  assign startNext = halfNext ? (posSum >> 1) : posSum;

  assign diff  = {1'b0, col} - {1'b0, startLat};
  assign inWin = (col >= startLat) &&
                 (diff < {{(COL_W-5){1'b0}}, (halfLat ? 6'd16 : 6'd32)});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      lineAddr  <= '0;
      fetchAddr <= '0;
      armed     <= 1'b0;
      halfLat   <= 1'b0;
      startLat  <= '0;
      col       <= '0;
    end else begin
      if (lineStart) begin
        fetchAddr <= nextFetch;
        lineAddr  <= nextFetch + ADDR_W'(LINE_STEP);
        state     <= ST_GET_AND;
        armed     <= 1'b0;
        halfLat   <= halfNext;
        startLat  <= startNext;
        col       <= '0;
      end else begin
        if (frameStart) lineAddr <= baseAddr;
        if (pixInValid && (col != '1)) col <= col + 1'b1;
        case (state)
          ST_GET_AND: if (memRdValid) state <= ST_GET_XOR;
          ST_GET_XOR: if (memRdValid) begin
            state <= ST_IDLE;
            armed <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign memRdReq = (state != ST_IDLE);
  assign memAddr  = (state == ST_GET_XOR) ? fetchAddr + ADDR_W'(XOR_GAP) : fetchAddr;

  always_comb begin
    strobe.loadAnd = (state == ST_GET_AND) && memRdValid && !lineStart;
    strobe.loadXor = (state == ST_GET_XOR) && memRdValid && !lineStart;
    strobe.apply   = armed && pixInValid && inWin && !lineStart;
    strobe.twoBit  = halfLat;
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdValid && !lineStart && !frameStart) |=> $stable(memAddr)) else $error("addr hold"); // R3
  AST_XOR_AFTER_AND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GET_AND && memRdValid && !lineStart) |=>
      (memRdReq && memAddr == $past(memAddr) + ADDR_W'(XOR_GAP))) else $error("xor gap"); // R3
  AST_NO_APPLY_UNARMED: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> !strobe.apply) else $error("apply before masks"); // R1
endmodule

// File: rtl/cursor_overlay_dp.sv
module cursor_overlay_dp
  import cursor_overlay_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ovlStrobe_t        strobe,
  input  logic [MASK_W-1:0] memRdData,
  input  logic              pixInValid,
  input  logic [23:0]       pixIn,
  output logic              pixOutValid,
  output logic [23:0]       pixOut
);
  logic [MASK_W-1:0] andSh, xorSh;
  logic [23:0]       painted;

  always_comb begin
    painted = andSh[MASK_W-1] ? pixIn : 24'h000000;
    if (xorSh[MASK_W-1]) painted = painted ^ 24'hFFFFFF;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      andSh       <= '0;
      xorSh       <= '0;
      pixOutValid <= 1'b0;
      pixOut      <= '0;
    end else begin
      if (strobe.loadAnd) andSh <= memRdData;
      else if (strobe.apply) andSh <= strobe.twoBit ? (andSh << 2) : (andSh << 1);
      if (strobe.loadXor) xorSh <= memRdData;
      else if (strobe.apply) xorSh <= strobe.twoBit ? (xorSh << 2) : (xorSh << 1);
      pixOutValid <= pixInValid;
      pixOut      <= strobe.apply ? painted : pixIn;
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    pixInValid |=> pixOutValid) else $error("latency"); // R2
  AST_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (pixInValid && !strobe.apply) |=> pixOut == $past(pixIn)) else $error("pass"); // R2
  AST_BLACK: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.apply && !andSh[MASK_W-1] && !xorSh[MASK_W-1]) |=> pixOut == 24'h000000) else $error("black"); // R4
  AST_INVERT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.apply && !andSh[MASK_W-1] && xorSh[MASK_W-1]) |=> pixOut == 24'hFFFFFF) else $error("invert"); // R5
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_overlay_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int X_W    = 11,
  parameter int T_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              lineStart,
  input  logic [7:0]        curSel,
  input  logic [1:0]        curBank,
  input  logic [X_W-1:0]    xPos,
  input  logic [X_W-1:0]    xOff,
  input  logic              is8bpp,
  input  logic              interlaced,
  input  logic              oddField,
  input  logic [T_W-1:0]    hTotal,
  input  logic [T_W-1:0]    vTotal,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdValid,
  input  logic [31:0]       memRdData,
  input  logic              pixInValid,
  input  logic [23:0]       pixIn,
  output logic              pixOutValid,
  output logic [23:0]       pixOut
);
  ovlStrobe_t strobe;

  cursor_overlay_ctrl #(.ADDR_W(ADDR_W), .X_W(X_W), .T_W(T_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .curSel(curSel), .curBank(curBank), .xPos(xPos), .xOff(xOff),
    .is8bpp(is8bpp), .interlaced(interlaced), .oddField(oddField),
    .hTotal(hTotal), .vTotal(vTotal), .pixInValid(pixInValid),
    .memRdValid(memRdValid), .memRdReq(memRdReq), .memAddr(memAddr),
    .strobe(strobe)
  );

  cursor_overlay_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memRdData(memRdData),
    .pixInValid(pixInValid), .pixIn(pixIn),
    .pixOutValid(pixOutValid), .pixOut(pixOut)
  );
endmodule

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;
  localparam int ADDR_W = 20;
  localparam int X_W    = 11;
  localparam int T_W    = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 0, lineStart = 0;
  logic [7:0] curSel = 0;
  logic [1:0] curBank = 0;
  logic [X_W-1:0] xPos = 0, xOff = 0;
  logic is8bpp = 0, interlaced = 0, oddField = 0;
  logic [T_W-1:0] hTotal = 0, vTotal = 0;
  logic memRdReq, memRdValid = 0;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0] memRdData = 0;
  logic pixInValid = 0;
  logic [23:0] pixIn = 0;
  logic pixOutValid;
  logic [23:0] pixOut;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [23:0] expQ[$];
  string tagQ[$];
  logic [ADDR_W-1:0] addrQ[$];
  logic [ADDR_W-1:0] modelLine = 0;

  always #5 clk = ~clk;

  cursor_overlay #(.ADDR_W(ADDR_W), .X_W(X_W), .T_W(T_W)) u_cursor_overlay (.*);

  function automatic logic [31:0] memWord(logic [ADDR_W-1:0] a);
    logic [31:0] h;
    h = {a[15:0] * 16'd7 + 16'h1357, a[15:0] ^ 16'hC3A5};
    return h ^ {h[15:0], h[31:16]} ^ 32'h96E1_5A3C;
  endfunction

  // memory model: answers each request in the cycle it is seen
  always @(negedge clk) begin
    memRdValid <= memRdReq;
    memRdData  <= memWord(memAddr);
    if (memRdReq) addrQ.push_back(memAddr);
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each produced pixel with the scoreboard
  always @(negedge clk) begin
    if (rstN && pixOutValid) begin
      if (expQ.size() == 0) check(0, "R2 unexpected output", {8'h0, pixOut}, 32'h0);
      else begin
        logic [23:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(pixOut === e, t, {8'h0, pixOut}, {8'h0, e});
      end
    end
  end

  task automatic sendPixels(int n, int start, int w, bit half, bit armed,
                            logic [31:0] andW, logic [31:0] xorW, int seed);
    for (int c = 0; c < n; c++) begin
      logic [23:0] p, e;
      string t;
      @(negedge clk);
      if ((c % 7) == 6) begin
        pixInValid = 0;
        @(negedge clk);
      end
      p = 24'(seed * 24'h1F3D5 + c * 24'h2B97 + 24'h5A);
      e = p;
      t = armed ? "R2 outside window" : "R1 pass before fetch";
      if (armed && c >= start && c < start + w) begin
        int b;
        b = half ? 31 - 2 * (c - start) : 31 - (c - start);
        t = half ? "R7 half window" : "R6 normal window";
        if (!andW[b]) begin e = 24'h0; t = {t, " R4"}; end
        if (xorW[b]) begin e = e ^ 24'hFFFFFF; t = {t, " R5"}; end
      end
      pixInValid = 1;
      pixIn = p;
      expQ.push_back(e);
      tagQ.push_back(t);
    end
    @(negedge clk);
    pixInValid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic doLine(bit frame, int xp, int xo, bit b8, bit intl, bit odd,
                        int ht, int vt, int n, int seed);
    logic [ADDR_W-1:0] fa;
    bit half;
    int start;
    half = b8 && (ht * 8 > (intl ? vt * 4 : vt * 2));
    start = half ? (xp + xo) / 2 : (xp + xo);
    if (frame) modelLine = ADDR_W'({curBank, 2'b11, curSel, 8'h00});
    fa = modelLine + ((intl && odd) ? 4 : 0);
    modelLine = fa + 4;
    @(negedge clk);
    frameStart = frame; lineStart = 1;
    xPos = X_W'(xp); xOff = X_W'(xo); is8bpp = b8; interlaced = intl; oddField = odd;
    hTotal = T_W'(ht); vTotal = T_W'(vt);
    @(negedge clk);
    frameStart = 0; lineStart = 0;
    repeat (2) @(negedge clk);
    #1;
    check(addrQ.size() == 2, "R3 fetch count", addrQ.size(), 2);
    if (addrQ.size() == 2) begin
      logic [ADDR_W-1:0] a0, a1;
      a0 = addrQ.pop_front();
      a1 = addrQ.pop_front();
      check(a0 == fa, (intl && odd) ? "R9 odd field AND address" : "R10 AND address", a0, fa);
      check(a1 == fa + 128, "R3 XOR address", a1, fa + 128);
    end
    addrQ.delete();
    sendPixels(n, start, half ? 16 : 32, half, 1, memWord(fa), memWord(fa + 128), seed);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(memRdReq === 1'b0, "R1 no request after reset", memRdReq, 0);
    check(pixOutValid === 1'b0, "R1 output idle after reset", pixOutValid, 0);
    sendPixels(10, 0, 32, 0, 0, 0, 0, 3);
    check(addrQ.size() == 0, "R1 no fetch without lineStart", addrQ.size(), 0);

    curSel = 8'h12; curBank = 2'd2;
    doLine(1, 5, 3, 0, 0, 0, 100, 100, 50, 11);   // R6 R10 base
    doLine(0, 0, 0, 0, 0, 0, 100, 100, 40, 12);   // R10 step, start at 0
    doLine(0, 20, 1, 1, 0, 0, 100, 300, 40, 13);  // R8 half (800>600), R7
    doLine(0, 20, 1, 1, 0, 0, 75, 300, 60, 14);   // R8 boundary 600==600 normal
    doLine(0, 7, 2, 1, 1, 1, 100, 200, 50, 15);   // R8 interlaced equal, R9
    doLine(0, 7, 2, 1, 1, 1, 101, 200, 40, 16);   // R8 interlaced half, R9 cumulative
    doLine(0, 3, 3, 1, 1, 0, 101, 200, 40, 17);   // even field no skip
    doLine(0, 9, 0, 0, 1, 1, 500, 10, 50, 18);    // R8 needs 8bpp, R9
    curSel = 8'hA7; curBank = 2'd1;
    doLine(1, 30, 4, 0, 0, 0, 100, 100, 40, 19);  // R10 reload, window past end
    doLine(1, 1, 1, 0, 1, 1, 100, 100, 40, 20);   // R10 reload then R9 skip

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2 all pixels emerged", expQ.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule